// File: doc/BRIEF.md
# RV64 Integer Shift Unit with Word Variants

This block is the shift datapath of a 64-bit RISC-V integer execute stage. It covers left logical, right logical and right arithmetic shifts on the full 64-bit operand, and the 32-bit word forms of the same three operations. The decode stage supplies three control bits: direction, arithmetic or logical, and word or doubleword. It also supplies the shift amount in two forms, one taken from a register and one from an immediate field, and a select that picks between them.

Internally the unit uses a single right-shifting barrel network. For a left shift the operand is bit-reversed on the way in and the result is reversed on the way out. For a word operation the operand is first narrowed to its low 32 bits. When the word operation is an arithmetic right shift, the bits above the word are filled with the word's own sign, bit 31, and never with bit 63. The result of every word operation is sign-extended from bit 31. The result is captured in a single output register, so it appears one clock after the request.

Top module: `shift_unit`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises with `req_vld_i` low, `rsp_vld_o` is 0 and `result_o` is 0.
- R2: `rsp_vld_o` equals the `req_vld_i` of the previous cycle. `result_o` is updated only on a cycle where `req_vld_i` was high, and otherwise it keeps its value.
- R3: A doubleword operation (`word_i`=0) shifts all 64 bits by amount[5:0]. Left shifts and logical right shifts fill with 0. An arithmetic right shift fills the vacated upper bits with input bit 63.
- R4: A word operation (`word_i`=1) depends only on bits 31:0 of `src_i`. Bits 63:32 of the input have no effect on the result.
- R5: The word arithmetic right shift (`right_i`=1, `arith_i`=1, `word_i`=1) fills both the vacated bits of the 32-bit word and all of result bits 63:32 with input bit 31. For example, src=0xFFFFFFFF_0CB9E1E7 shifted by 3 gives 0x00000000_0197 3C3C written without the space, that is 0x0000000001973C3C.
- R6: A word left shift and a word logical right shift produce a 32-bit value that is sign-extended to 64 bits from its own bit 31.
- R7: A word operation uses only amount[4:0]. Amount bit 5 is ignored.
- R8: With `use_imm_i`=1 the amount comes from `imm_amt_i`, and with `use_imm_i`=0 it comes from `reg_amt_i`. The same amount gives the same result from either source.
- R9: A word operation with amount 0 returns `src_i[31:0]` sign-extended to 64 bits, for all three operation kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request valid |
| src_i | input | 64 | Operand to shift |
| reg_amt_i | input | 6 | Shift amount from the register operand (low bits of rs2) |
| imm_amt_i | input | 6 | Shift amount from the immediate field |
| use_imm_i | input | 1 | 1 selects `imm_amt_i`, 0 selects `reg_amt_i` |
| right_i | input | 1 | 1 shifts right, 0 shifts left |
| arith_i | input | 1 | 1 selects an arithmetic right shift (ignored for left shifts) |
| word_i | input | 1 | 1 selects a 32-bit word operation, 0 a 64-bit operation |
| rsp_vld_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Shift result |

## Verification
The assertions compare each registered result with the request of the previous cycle. They assume that the control and operand inputs are stable and known on every cycle in which `req_vld_i` is high, and that reset is applied synchronously for at least one clock edge. The bench meets this by changing inputs only on the falling edge, by holding `req_vld_i` low during reset, and by driving defined values on every pin at all times. Its operands include values where bit 31 and bit 63 differ, and word operations whose amounts have bit 5 set.

// File: rtl/shift_pkg.sv
package shift_pkg;
    localparam int XLEN = 64;
    localparam int WLEN = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    typedef struct packed {
        logic right;
        logic arith;
        logic word;
    } shift_ctrl_t;
endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
    parameter int SHW = 6
) (
    input  logic [SHW-1:0] reg_amt_i,
    input  logic [SHW-1:0] imm_amt_i,
    input  logic           use_imm_i,
    input  logic           word_i,
    output logic [SHW-1:0] amt_o
);
    logic [SHW-1:0] raw_amt;

    always_comb begin
        raw_amt = use_imm_i ? imm_amt_i : reg_amt_i;
        amt_o   = raw_amt;
        // word forms only honour the low SHW-1 bits of the amount
        if (word_i) amt_o[SHW-1] = 1'b0;
    end
endmodule

// File: rtl/shift_operand_prep.sv
module shift_operand_prep
    import shift_pkg::*;
#(
    parameter int XW = 64
) (
    input  logic [XW-1:0] src_i,
    input  shift_ctrl_t   ctrl_i,
    output logic [XW-1:0] base_o,
    output logic          fill_o
);
    localparam int WW = XW / 2;

    logic [XW-1:0] rev_src;
    logic          word_sign;

    for (genvar i = 0; i < XW; i++) begin : g_rev
        assign rev_src[i] = src_i[XW-1-i];
    end

    always_comb begin
        word_sign = ctrl_i.arith & src_i[WW-1];
        if (!ctrl_i.right) begin
            base_o = rev_src;
            fill_o = 1'b0;
        end else if (ctrl_i.word) begin
            base_o = {{WW{word_sign}}, src_i[WW-1:0]};
            fill_o = word_sign;
        end else begin
            base_o = src_i;
            fill_o = ctrl_i.arith & src_i[XW-1];
        end
    end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
    parameter int XW  = 64,
    parameter int SHW = 6
) (
    input  logic [XW-1:0]  base_i,
    input  logic           fill_i,
    input  logic [SHW-1:0] amt_i,
    output logic [XW-1:0]  res_o
);
    logic [XW-1:0] stg [SHW+1];

    assign stg[0] = base_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{D{fill_i}}, stg[k][XW-1:D]} : stg[k];
    end

    assign res_o = stg[SHW];
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_vld_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [SHW-1:0]  reg_amt_i,
    input  logic [SHW-1:0]  imm_amt_i,
    input  logic            use_imm_i,
    input  logic            right_i,
    input  logic            arith_i,
    input  logic            word_i,
    output logic            rsp_vld_o,
    output logic [XLEN-1:0] result_o
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
    } out_t;

    shift_ctrl_t     ctrl;
    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] base;
    logic            fill;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] unrev;
    logic [XLEN-1:0] final_res;
    out_t            out_d, out_q;

    assign ctrl = '{right: right_i, arith: arith_i, word: word_i};

    shift_amt_sel #(.SHW(SHW)) amt_sel_i (
        .reg_amt_i (reg_amt_i),
        .imm_amt_i (imm_amt_i),
        .use_imm_i (use_imm_i),
        .word_i    (word_i),
        .amt_o     (amt)
    );

    shift_operand_prep #(.XW(XLEN)) prep_i (
        .src_i  (src_i),
        .ctrl_i (ctrl),
        .base_o (base),
        .fill_o (fill)
    );

    shift_barrel #(.XW(XLEN), .SHW(SHW)) barrel_i (
        .base_i (base),
        .fill_i (fill),
        .amt_i  (amt),
        .res_o  (shifted)
    );

    for (genvar i = 0; i < XLEN; i++) begin : g_unrev
        assign unrev[i] = shifted[XLEN-1-i];
    end

    always_comb begin
        final_res = ctrl.right ? shifted : unrev;
        if (ctrl.word) final_res = {{WLEN{final_res[WLEN-1]}}, final_res[WLEN-1:0]};
        out_d.vld = req_vld_i;
        out_d.res = req_vld_i ? final_res : out_q.res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_vld_o = out_q.vld;
    assign result_o  = out_q.res;

    // R2: the valid flag follows the request with one cycle of latency
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o == $past(req_vld_i));

    // R2: without a request the result register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> $stable(result_o));

    // R6: every word result is sign-extended from its bit 31
    a_r6_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && word_i |=> result_o[XLEN-1:WLEN] == {WLEN{result_o[WLEN-1]}});

    // R5: the word arithmetic right shift keeps the sign of input bit 31
    a_r5_sraw_sign: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && word_i && right_i && arith_i |=> result_o[XLEN-1] == $past(src_i[WLEN-1]));

    // R3: the doubleword arithmetic right shift keeps bit 63
    a_r3_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && !word_i && right_i && arith_i |=> result_o[XLEN-1] == $past(src_i[XLEN-1]));

    // R9: a word shift by zero returns the low word unchanged
    a_r9_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && word_i && (use_imm_i ? imm_amt_i[SHW-2:0] : reg_amt_i[SHW-2:0]) == '0
        |=> result_o[WLEN-1:0] == $past(src_i[WLEN-1:0]));
endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld_i = 1'b0;
    logic [63:0] src_i = '0;
    logic [5:0]  reg_amt_i = '0;
    logic [5:0]  imm_amt_i = '0;
    logic        use_imm_i = 1'b0;
    logic        right_i = 1'b0;
    logic        arith_i = 1'b0;
    logic        word_i = 1'b0;
    logic        rsp_vld_o;
    logic [63:0] result_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // operation codes used by the bench: {right, arith, word}
    localparam logic [2:0] OP_SLL  = 3'b000, OP_SRL  = 3'b100, OP_SRA  = 3'b110;
    localparam logic [2:0] OP_SLLW = 3'b001, OP_SRLW = 3'b101, OP_SRAW = 3'b111;

    always #10 clk = ~clk;

    shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i), .src_i(src_i),
        .reg_amt_i(reg_amt_i), .imm_amt_i(imm_amt_i), .use_imm_i(use_imm_i),
        .right_i(right_i), .arith_i(arith_i), .word_i(word_i),
        .rsp_vld_o(rsp_vld_o), .result_o(result_o)
    );

    function automatic logic [63:0] ref_model(logic [2:0] op, logic [63:0] s, logic [5:0] a);
        logic [31:0] w;
        logic [31:0] wr;
        w = s[31:0];
        case (op)
            OP_SLL:  return s << a;
            OP_SRL:  return s >> a;
            OP_SRA:  return $unsigned($signed(s) >>> a);
            OP_SLLW: wr = w << a[4:0];
            OP_SRLW: wr = w >> a[4:0];
            OP_SRAW: wr = $unsigned($signed(w) >>> a[4:0]);
            default: wr = '0;
        endcase
        return {{32{wr[31]}}, wr};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request on the falling edge; the result is registered on the
    // next rising edge and sampled on the falling edge after it
    task automatic run_op(string req, logic [2:0] op, logic [63:0] s, logic [5:0] a, logic imm);
        @(negedge clk);
        req_vld_i = 1'b1;
        {right_i, arith_i, word_i} = op;
        src_i = s;
        use_imm_i = imm;
        if (imm) begin imm_amt_i = a; reg_amt_i = ~a; end
        else     begin reg_amt_i = a; imm_amt_i = ~a; end
        @(negedge clk);
        req_vld_i = 1'b0;
        check(req, {63'd0, rsp_vld_o}, 64'd1);
        check(req, result_o, ref_model(op, s, a));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 vld", {63'd0, rsp_vld_o}, 64'd0);
        check("R1 res", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after", {63'd0, rsp_vld_o}, 64'd0);
        check("R1 res after", result_o, 64'd0);
    endtask

    task automatic t_doubleword();
        run_op("R3 sll", OP_SLL, 64'h8000_0001_8000_0001, 6'd33, 1'b0);
        run_op("R3 srl", OP_SRL, 64'hF000_0000_0000_0000, 6'd63, 1'b0);
        run_op("R3 sra neg", OP_SRA, 64'h8000_0000_0000_0010, 6'd4, 1'b0);
        run_op("R3 sra pos b31", OP_SRA, 64'h0000_0000_FFFF_FFFF, 6'd40, 1'b0);
        run_op("R3 sra 63", OP_SRA, 64'h8000_0000_0000_0000, 6'd63, 1'b1);
    endtask

    task automatic t_sraw();
        run_op("R5 example", OP_SRAW, 64'hFFFF_FFFF_0CB9_E1E7, 6'd3, 1'b0);
        check("R5 example const", result_o, 64'h0000_0000_0197_3C3C);
        run_op("R5 neg word pos top", OP_SRAW, 64'h0000_0000_8000_0000, 6'd31, 1'b1);
        run_op("R5 neg word", OP_SRAW, 64'h7FFF_FFFF_F000_0000, 6'd8, 1'b0);
    endtask

    task automatic t_word_logical();
        run_op("R6 sllw sext", OP_SLLW, 64'h0000_0000_0000_0001, 6'd31, 1'b0);
        run_op("R6 srlw", OP_SRLW, 64'hFFFF_FFFF_8000_0000, 6'd1, 1'b1);
        run_op("R6 srlw zero amt", OP_SRLW, 64'h0000_0000_8000_0000, 6'd0, 1'b0);
    endtask

    task automatic t_upper_ignored();
        for (int op = 0; op < 3; op++) begin
            logic [2:0] o;
            o = (op == 0) ? OP_SLLW : (op == 1) ? OP_SRLW : OP_SRAW;
            run_op("R4 upper ones", o, 64'hFFFF_FFFF_1234_5678, 6'd5, 1'b0);
            check("R4 vs upper zero", result_o, ref_model(o, 64'h0000_0000_1234_5678, 6'd5));
        end
    endtask

    task automatic t_amt_bit5();
        run_op("R7 srlw bit5", OP_SRLW, 64'h0000_0000_F000_000F, 6'd36, 1'b0);
        check("R7 srlw same as 4", result_o, 64'h0000_0000_0F00_0000);
        run_op("R7 sllw bit5", OP_SLLW, 64'h0000_0000_0000_0003, 6'd33, 1'b1);
        check("R7 sllw same as 1", result_o, 64'h0000_0000_0000_0006);
    endtask

    task automatic t_imm_vs_reg();
        logic [63:0] r_reg;
        run_op("R8 reg", OP_SRAW, 64'h1234_5678_9ABC_DEF0, 6'd13, 1'b0);
        r_reg = result_o;
        run_op("R8 imm", OP_SRAW, 64'h1234_5678_9ABC_DEF0, 6'd13, 1'b1);
        check("R8 imm equals reg", result_o, r_reg);
    endtask

    task automatic t_zero_amt();
        run_op("R9 sraw 0", OP_SRAW, 64'h0000_0000_8765_4321, 6'd0, 1'b0);
        run_op("R9 sllw 0", OP_SLLW, 64'hFFFF_FFFF_7654_3210, 6'd32, 1'b1);
        run_op("R9 srlw 0", OP_SRLW, 64'h1111_1111_ABCD_0000, 6'd0, 1'b0);
    endtask

    task automatic t_hold();
        logic [63:0] held;
        run_op("R2 setup", OP_SRL, 64'hDEAD_BEEF_0000_0000, 6'd16, 1'b0);
        held = result_o;
        @(negedge clk);
        src_i = 64'h5555_5555_5555_5555;
        @(negedge clk);
        check("R2 vld low", {63'd0, rsp_vld_o}, 64'd0);
        check("R2 hold", result_o, held);
    endtask

    task automatic t_random();
        logic [2:0] ops [6] = '{OP_SLL, OP_SRL, OP_SRA, OP_SLLW, OP_SRLW, OP_SRAW};
        for (int n = 0; n < 300; n++) begin
            logic [63:0] s;
            s = {$urandom(), $urandom()};
            if (n % 3 == 0) s[63] = ~s[31];
            run_op("R3/R4/R5/R6 random", ops[n % 6], s, 6'($urandom()), 1'($urandom()));
        end
    endtask

    initial begin
        t_reset();
        t_doubleword();
        t_sraw();
        t_word_logical();
        t_upper_ignored();
        t_amt_bit5();
        t_imm_vs_reg();
        t_zero_amt();
        t_hold();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule